// File: doc/BRIEF.md
# Low-Power Domain Register Write Bridge

This block carries register writes from a fast bus clock into a slow, always-on timekeeping domain that runs near 32 kHz. Every bus write, except one aimed at the interrupt-enable register, is latched on the bus side. It then crosses into the slow domain through a toggle request and acknowledge pair. There it is presented for one slow cycle to the register file that owns the data. That register file is outside this block.

Software tracks progress through four status bits: busy, ready for the next write, complete, and error. Complete is cleared by reading the status register. Error is raised when a write arrives while another write is still in flight, and it is cleared by a synchronised write of a 1 to its own bit position. Writes to the interrupt-enable register stay in the bus domain and take effect on the next bus cycle. The enable bits gate next, complete and error onto a single interrupt line.

Top module: `lp_write_bridge`

## Requirements
- R1: After reset, the status word reads 0x200. The status bit positions are: busy is bit 10, next is bit 9, complete is bit 8, error is bit 7. All other bits read 0. The interrupt output is low and no slow-domain write is presented.
- R2: A write to any address other than `IEN_ADDR` may arrive while busy is low. It is accepted, and from the next bus cycle busy reads 1 and next reads 0.
- R3: Each accepted write is presented in the slow domain exactly once. It appears as a `lp_wr_valid` pulse one slow cycle wide, carrying the same address and data.
- R4: When an accepted write has been applied, the bridge clears busy, sets next and sets complete, all in the same bus cycle. This happens within a bounded number of cycles, far below 1 ms.
- R5: A status read (`rd_stat`) clears complete on the next bus cycle. If a completion lands in the same cycle, the completion wins.
- R6: A write to `IEN_ADDR` takes effect on the next bus cycle, even while busy. It never sets busy, never sets complete, never raises error and is never presented in the slow domain.
- R7: A write to any address other than `IEN_ADDR` that arrives while busy is high is dropped. It is not presented in the slow domain, and error reads 1 from the next bus cycle.
- R8: Error is cleared only when a synchronised write to `STAT_ADDR` with data bit 7 set completes. The same write with bit 7 clear leaves error set.
- R9: The interrupt is the OR of three terms: enable bit 9 AND next, enable bit 8 AND complete, and enable bit 7 AND error. Here the enable bits are the data bits of the last interrupt-enable write, and they reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast bus clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | DATA_W | Bus write data |
| rd_stat | input | 1 | Strobe marking a read of the status register |
| stat_word | output | DATA_W | Status register value |
| irq | output | 1 | Gated write-progress interrupt |
| lp_clk | input | 1 | Slow low-power domain clock |
| lp_rst | input | 1 | Synchronous active-high reset, slow domain |
| lp_wr_valid | output | 1 | One-slow-cycle pulse applying a write |
| lp_wr_addr | output | ADDR_W | Address of the applied write |
| lp_wr_data | output | DATA_W | Data of the applied write |

## Verification
On every bus cycle the assertions check several local rules. A write accepted while idle raises busy, and one arriving while busy raises error. Complete can only rise in the cycle busy falls. An idle status read leaves complete clear. An interrupt-enable write never raises busy. In the slow domain the assertions also check that an applied write never lasts more than one cycle. Only the bench scenarios can show what spans the two clocks: the address and data that arrive on the slow side, the exact count of slow-side pulses per write, that a dropped write never shows up there, and the error-clear and interrupt-gating sequences.

// File: rtl/wb_pkg.sv
package wb_pkg;

    // Status bit positions (software decodes these)
    localparam int BIT_ERR  = 7;
    localparam int BIT_DONE = 8;
    localparam int BIT_NEXT = 9;
    localparam int BIT_BUSY = 10;

    typedef struct packed {
        logic busy;
        logic next;
        logic done;
        logic err;
    } wr_flags_t;

    // gate[2] enables next, gate[1] enables done, gate[0] enables error
    function automatic logic flags_irq(wr_flags_t f, logic [2:0] gate);
        return (gate[2] & f.next) | (gate[1] & f.done) | (gate[0] & f.err);
    endfunction

endpackage

// File: rtl/wb_sync2.sv
module wb_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/wb_lp_apply.sv
module wb_lp_apply #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              lp_clk,
    input  logic              lp_rst,
    input  logic              req_tgl,
    input  logic [ADDR_W-1:0] hold_addr,
    input  logic [DATA_W-1:0] hold_data,
    output logic              ack_tgl,
    output logic              lp_wr_valid,
    output logic [ADDR_W-1:0] lp_wr_addr,
    output logic [DATA_W-1:0] lp_wr_data
);
    logic req_s;
    logic new_req;

    wb_sync2 #(.W(1)) u_req_sync (
        .clk (lp_clk),
        .rst (lp_rst),
        .d   (req_tgl),
        .q   (req_s)
    );

    assign new_req = req_s ^ ack_tgl;

    // The hold registers are stable while the request is outstanding.
    always_ff @(posedge lp_clk) begin
        if (lp_rst) begin
            ack_tgl     <= 1'b0;
            lp_wr_valid <= 1'b0;
            lp_wr_addr  <= '0;
            lp_wr_data  <= '0;
        end else begin
            lp_wr_valid <= new_req;
            ack_tgl     <= req_s;
            if (new_req) begin
                lp_wr_addr <= hold_addr;
                lp_wr_data <= hold_data;
            end
        end
    end
endmodule

// File: rtl/wb_bus_ctl.sv
module wb_bus_ctl
    import wb_pkg::*;
#(
    parameter int                ADDR_W    = 5,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 'h0C,
    parameter logic [ADDR_W-1:0] IEN_ADDR  = 'h10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stat,
    input  logic              ack_s,
    output logic              req_tgl,
    output logic [ADDR_W-1:0] hold_addr,
    output logic [DATA_W-1:0] hold_data,
    output wr_flags_t         flags,
    output logic [2:0]        ien_gate
);
    logic ack_prev;
    logic done_r;
    logic err_r;
    logic busy;
    logic cmp_ev;
    logic is_ien;
    logic take;
    logic drop;
    logic clr_err;

    // Busy uses the delayed acknowledge so it falls with the done set.
    assign busy    = req_tgl ^ ack_prev;
    assign cmp_ev  = ack_s ^ ack_prev;
    assign is_ien  = (wr_addr == IEN_ADDR);
    assign take    = wr_en && !is_ien && !busy;
    assign drop    = wr_en && !is_ien && busy;
    assign clr_err = cmp_ev && (hold_addr == STAT_ADDR) && hold_data[BIT_ERR];

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_prev  <= 1'b0;
            req_tgl   <= 1'b0;
            hold_addr <= '0;
            hold_data <= '0;
            done_r    <= 1'b0;
            err_r     <= 1'b0;
            ien_gate  <= '0;
        end else begin
            ack_prev <= ack_s;
            if (take) begin
                req_tgl   <= ~req_tgl;
                hold_addr <= wr_addr;
                hold_data <= wr_data;
            end
            if (cmp_ev)
                done_r <= 1'b1;
            else if (rd_stat)
                done_r <= 1'b0;
            if (drop)
                err_r <= 1'b1;
            else if (clr_err)
                err_r <= 1'b0;
            if (wr_en && is_ien)
                ien_gate <= {wr_data[BIT_NEXT], wr_data[BIT_DONE], wr_data[BIT_ERR]};
        end
    end

    always_comb begin
        flags.busy = busy;
        flags.next = ~busy;
        flags.done = done_r;
        flags.err  = err_r;
    end
endmodule

// File: rtl/lp_write_bridge.sv
module lp_write_bridge
    import wb_pkg::*;
#(
    parameter int                ADDR_W    = 5,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 'h0C,
    parameter logic [ADDR_W-1:0] IEN_ADDR  = 'h10
) (
    input  logic              bus_clk,
    input  logic              bus_rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stat,
    output logic [DATA_W-1:0] stat_word,
    output logic              irq,
    input  logic              lp_clk,
    input  logic              lp_rst,
    output logic              lp_wr_valid,
    output logic [ADDR_W-1:0] lp_wr_addr,
    output logic [DATA_W-1:0] lp_wr_data
);
    logic              req_tgl;
    logic              ack_tgl;
    logic              ack_s;
    logic [ADDR_W-1:0] hold_addr;
    logic [DATA_W-1:0] hold_data;
    wr_flags_t         flags;
    logic [2:0]        ien_gate;

    wb_bus_ctl #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .STAT_ADDR (STAT_ADDR),
        .IEN_ADDR  (IEN_ADDR)
    ) u_bus (
        .clk       (bus_clk),
        .rst       (bus_rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_stat   (rd_stat),
        .ack_s     (ack_s),
        .req_tgl   (req_tgl),
        .hold_addr (hold_addr),
        .hold_data (hold_data),
        .flags     (flags),
        .ien_gate  (ien_gate)
    );

    wb_sync2 #(.W(1)) u_ack_sync (
        .clk (bus_clk),
        .rst (bus_rst),
        .d   (ack_tgl),
        .q   (ack_s)
    );

    wb_lp_apply #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_lp (
        .lp_clk      (lp_clk),
        .lp_rst      (lp_rst),
        .req_tgl     (req_tgl),
        .hold_addr   (hold_addr),
        .hold_data   (hold_data),
        .ack_tgl     (ack_tgl),
        .lp_wr_valid (lp_wr_valid),
        .lp_wr_addr  (lp_wr_addr),
        .lp_wr_data  (lp_wr_data)
    );

    always_comb begin
        stat_word           = '0;
        stat_word[BIT_BUSY] = flags.busy;
        stat_word[BIT_NEXT] = flags.next;
        stat_word[BIT_DONE] = flags.done;
        stat_word[BIT_ERR]  = flags.err;
    end

    assign irq = flags_irq(flags, ien_gate);
endmodule

// File: rtl/lp_write_bridge_chk.sv
module lp_write_bridge_chk #(
    parameter int                ADDR_W   = 5,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] IEN_ADDR = 'h10
) (
    input logic              bus_clk,
    input logic              bus_rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              rd_stat,
    input logic [DATA_W-1:0] stat_word,
    input logic              lp_clk,
    input logic              lp_rst,
    input logic              lp_wr_valid
);
    AST_ACCEPT_SETS_BUSY: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (wr_en && wr_addr != IEN_ADDR && !stat_word[10]) |=> stat_word[10]); // R2

    AST_DROP_SETS_ERR: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (wr_en && wr_addr != IEN_ADDR && stat_word[10]) |=> stat_word[7]); // R7

    AST_DONE_WITH_BUSY_FALL: assert property (@(posedge bus_clk) disable iff (bus_rst)
        $rose(stat_word[8]) |-> $fell(stat_word[10])); // R4

    AST_READ_CLEARS_DONE: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (rd_stat && !stat_word[10]) |=> !stat_word[8]); // R5

    AST_IEN_NO_BUSY: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (wr_en && wr_addr == IEN_ADDR && !stat_word[10]) |=> !stat_word[10]); // R6

    AST_LP_SINGLE_PULSE: assert property (@(posedge lp_clk) disable iff (lp_rst)
        lp_wr_valid |=> !lp_wr_valid); // R3
endmodule

bind lp_write_bridge lp_write_bridge_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .IEN_ADDR (IEN_ADDR)
) u_chk (
    .bus_clk     (bus_clk),
    .bus_rst     (bus_rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .rd_stat     (rd_stat),
    .stat_word   (stat_word),
    .lp_clk      (lp_clk),
    .lp_rst      (lp_rst),
    .lp_wr_valid (lp_wr_valid)
);

// File: tb/lp_write_bridge_tb.sv
module lp_write_bridge_tb;
    localparam int          AW   = 5;
    localparam int          DW   = 32;
    localparam logic [4:0]  STAT = 5'h0C;
    localparam logic [4:0]  IEN  = 5'h10;

    logic          bus_clk = 1'b0;
    logic          lp_clk  = 1'b0;
    logic          bus_rst = 1'b1;
    logic          lp_rst  = 1'b1;
    logic          wr_en   = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_stat = 1'b0;
    logic [DW-1:0] stat_word;
    logic          irq;
    logic          lp_wr_valid;
    logic [AW-1:0] lp_wr_addr;
    logic [DW-1:0] lp_wr_data;

    int            checks = 0;
    int            fails  = 0;
    int            pulses = 0;
    logic [AW-1:0] last_a = '0;
    logic [DW-1:0] last_d = '0;
    int            cyc    = 0;
    bit            ended  = 0;

    always #2  bus_clk = ~bus_clk;   // 250 MHz
    always #15 lp_clk  = ~lp_clk;

    lp_write_bridge #(
        .ADDR_W (AW), .DATA_W (DW), .STAT_ADDR (STAT), .IEN_ADDR (IEN)
    ) u_dut (
        .bus_clk (bus_clk), .bus_rst (bus_rst), .wr_en (wr_en),
        .wr_addr (wr_addr), .wr_data (wr_data), .rd_stat (rd_stat),
        .stat_word (stat_word), .irq (irq), .lp_clk (lp_clk),
        .lp_rst (lp_rst), .lp_wr_valid (lp_wr_valid),
        .lp_wr_addr (lp_wr_addr), .lp_wr_data (lp_wr_data)
    );

    always @(negedge lp_clk) begin
        if (lp_wr_valid) begin
            pulses = pulses + 1;
            last_a = lp_wr_addr;
            last_d = lp_wr_data;
        end
    end

    always @(posedge bus_clk) begin
        cyc = cyc + 1;
        if (cyc == 150000 && !ended) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge bus_clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge bus_clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_pulse();
        @(negedge bus_clk);
        rd_stat = 1'b1;
        @(negedge bus_clk);
        rd_stat = 1'b0;
    endtask

    // R4: wait for complete with a bound, then let the slow monitor settle
    task automatic wait_done();
        int n = 0;
        while (stat_word[8] !== 1'b1 && n < 400) begin
            @(negedge bus_clk);
            n++;
        end
        chk("R4 completion within bound", 32'(n < 400), 32'd1);
        @(negedge lp_clk);
        @(negedge bus_clk);
    endtask

    initial begin
        int p0;
        repeat (4) @(negedge lp_clk);
        @(negedge bus_clk);
        bus_rst = 1'b0; lp_rst = 1'b0;
        @(negedge bus_clk);
        // R1
        chk("R1 status after reset", stat_word, 32'h200);
        chk("R1 irq after reset", 32'(irq), 32'd0);
        chk("R1 no slow write", 32'(lp_wr_valid), 32'd0);

        // R2 R3 R4 R5 sweep of every non-enable address
        for (int a = 0; a < 32; a++) begin
            logic [DW-1:0] d;
            if (a == int'(IEN)) continue;
            d  = (32'h9E3779B9 * 32'(a + 1)) ^ 32'(a << 3);
            if (a == int'(STAT)) d[7] = 1'b0;
            p0 = pulses;
            bus_wr(5'(a), d);
            chk("R2 busy/next after accept", 32'(stat_word[10:9]), 32'd2);
            wait_done();
            chk("R4 flags after completion", 32'(stat_word[10:7]), 32'b0110);
            chk("R3 one slow pulse", 32'(pulses - p0), 32'd1);
            chk("R3 slow address", 32'(last_a), 32'(a));
            chk("R3 slow data", last_d, d);
            rd_pulse();
            chk("R5 read clears complete", 32'(stat_word[8]), 32'd0);
        end

        // R6 enable write during busy, next gate enabled
        p0 = pulses;
        bus_wr(5'h03, 32'h1234_5678);
        bus_wr(IEN, 32'h200);
        chk("R6 enable write during busy no error", 32'(stat_word[7]), 32'd0);
        chk("R9 next gate off while busy", 32'(irq), 32'd0);
        wait_done();
        chk("R9 next gate on when idle", 32'(irq), 32'd1);
        chk("R6 enable write not forwarded", 32'(pulses - p0), 32'd1);
        chk("R6 forwarded data is first write", last_d, 32'h1234_5678);
        rd_pulse();

        // R6 enable write while idle: no busy, no complete, no slow write
        p0 = pulses;
        bus_wr(IEN, 32'h100);
        chk("R6 enable write sets no busy", 32'(stat_word[10:7]), 32'b0100);
        repeat (6) @(negedge lp_clk);
        @(negedge bus_clk);
        chk("R6 enable write sets no complete", 32'(stat_word[8]), 32'd0);
        chk("R6 enable write no slow pulse", 32'(pulses - p0), 32'd0);
        chk("R9 done gate off when not complete", 32'(irq), 32'd0);
        bus_wr(5'h05, 32'hCAFE_0001);
        wait_done();
        chk("R9 done gate raises irq", 32'(irq), 32'd1);
        rd_pulse();
        chk("R5 R9 read drops irq", 32'(irq), 32'd0);

        // R7 write while busy is dropped
        p0 = pulses;
        bus_wr(5'h06, 32'hAAAA_0006);
        bus_wr(5'h07, 32'hBBBB_0007);
        chk("R7 error after dropped write", 32'(stat_word[7]), 32'd1);
        wait_done();
        chk("R7 dropped write not forwarded", 32'(pulses - p0), 32'd1);
        chk("R7 forwarded address is first", 32'(last_a), 32'h06);
        chk("R7 forwarded data is first", last_d, 32'hAAAA_0006);
        rd_pulse();

        // R8 error clear rules, R9 error gate
        bus_wr(IEN, 32'h080);
        chk("R9 error gate raises irq", 32'(irq), 32'd1);
        bus_wr(STAT, 32'h0000_0100);
        wait_done();
        chk("R8 bit7 clear leaves error", 32'(stat_word[7]), 32'd1);
        rd_pulse();
        bus_wr(STAT, 32'h0000_0080);
        wait_done();
        chk("R8 bit7 set clears error", 32'(stat_word[7]), 32'd0);
        chk("R9 irq low after error clear", 32'(irq), 32'd0);

        ended = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule